// File: doc/BRIEF.md
# In-Place Radix-2 FFT Engine

This block computes a complex radix-2 decimation-in-time FFT, or its inverse, over one working memory. Before a transform begins, the memory already holds the samples in bit-reversed address order. The engine overwrites them with the frequency bins in natural order. It holds no sample storage of its own. It drives the address, write strobe and write data of a single-port memory and takes back read data with one cycle of latency. A twiddle table is computed when the design is elaborated.

One pulse on the start input begins a transform. The direction input is sampled on that pulse. Every butterfly reads two words and then writes two words back to the same addresses. The engine walks through the stages, the groups inside a stage and the butterflies inside a group in a fixed order. A one-cycle done pulse marks the end of the transform. Each stage halves its outputs with rounding, so the results are divided by N in total. This makes the forward result the spectrum divided by N, and the inverse result a true inverse transform.

Top module: `fft_inplace_engine`

## Requirements
- R1: After reset, `done` and `mem_wr` are low, and they stay low while no start pulse arrives.
- R2: A transform has log2(N) stages. In stage s (s = 1..log2(N)), the group base k steps by 2^s from 0 to N-1 and the inner index j runs from 0 to 2^(s-1)-1. Each butterfly writes address a = k+j first and then address b = a + 2^(s-1).
- R3: Each butterfly reads a, then reads b, then writes a, then writes b. The writes are round((u+t)/2) to a and round((u-t)/2) to b. Here u is the word at a, and t is the word at b multiplied by the twiddle with table index j·N/2^s, rounded to integer.
- R4: In forward mode, with input x[n] loaded at bit-reversed address rev(n), address k ends up holding sum over n of x[n]·e^(-2πi·nk/N) divided by N. Each part is within 6 LSB.
- R5: In inverse mode, address k ends up holding sum over n of x[n]·e^(+2πi·nk/N) divided by N. Each part is within 6 LSB.
- R6: `done` is high for exactly one cycle. It rises in the cycle after the last write, which is the 5·(N/2)·log2(N)+1-th cycle after the clock edge that samples `start`.
- R7: A start pulse during a transform is ignored. The result, the direction and the timing of `done` are those of the transform already running.
- R8: A memory word is {real[31:16], imaginary[15:0]}, both two's complement. Inputs whose complex modulus is below 2^15 produce no overflow. Any overflow that does occur saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a transform |
| inverse | input | 1 | Direction, sampled with start: 1 = inverse |
| mem_addr | output | LOG2N | Working memory address |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 2·DW | Write data {re, im} |
| mem_rdata | input | 2·DW | Read data, valid one cycle after the address |
| done | output | 1 | One-cycle end-of-transform pulse |

## Verification
The hardest property to see from the ports is the exact pairing and order of butterflies deep inside the middle stages. A wrong twiddle stride or a wrong pair distance there still gives a plausible spectrum for symmetric inputs. The bench therefore runs a 16-point engine and uses patterns with no symmetry: a pseudo-random complex sequence and an off-grid tone. It logs every write address and compares the log against the triple loop recomputed in the bench. It also sends a start pulse with the opposite direction in the middle of a run, to show that the direction latched at the first pulse is the one that governs.

// File: rtl/fft_inplace_engine.sv
module fft_inplace_engine #(
  parameter int LOG2N = 9,
  parameter int DW    = 16,
  parameter int TWW   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              inverse,
  output logic [LOG2N-1:0]  mem_addr,
  output logic              mem_wr,
  output logic [2*DW-1:0]   mem_wdata,
  input  logic [2*DW-1:0]   mem_rdata,
  output logic              done
);
  localparam int N     = 1 << LOG2N;
  localparam int HN    = N / 2;
  localparam int TFRAC = TWW - 2;
  localparam int SW    = $clog2(LOG2N + 1);
  localparam int PW    = DW + TWW + 1;
  localparam logic signed [PW-1:0] RC = PW'(1) << (TFRAC - 1);

  typedef enum logic [2:0] {S_IDLE, S_RA, S_RB, S_MUL, S_WA, S_WB} state_t;

  // twiddle table: W^i = cos - j sin, Q(TFRAC)
  logic signed [TWW-1:0] tw_cos [HN];
  logic signed [TWW-1:0] tw_sin [HN];
  for (genvar i = 0; i < HN; i++) begin : g_tw
    localparam real ANG = 6.283185307179586 * i / N;
    localparam int  CV  = $rtoi($floor($cos(ANG) * real'(1 << TFRAC) + 0.5));
    localparam int  SV  = $rtoi($floor($sin(ANG) * real'(1 << TFRAC) + 0.5));
    assign tw_cos[i] = TWW'(CV);
    assign tw_sin[i] = TWW'(SV);
  end

  state_t                 state;
  logic [SW-1:0]          st;
  logic [LOG2N-2:0]       bf;
  logic                   inv;
  logic                   done_r;
  logic signed [DW-1:0]   u_re, u_im;
  logic signed [DW+1:0]   t_re, t_im;

  // butterfly addressing
  logic [LOG2N-2:0] jmask, j, grp, tidx;
  logic [LOG2N-1:0] a, b;
  assign jmask = ~({(LOG2N-1){1'b1}} << st);
  assign j     = bf & jmask;
  assign grp   = bf >> st;
  assign a     = ({1'b0, grp} << (st + 1)) | {1'b0, j};
  assign b     = a | ({{(LOG2N-1){1'b0}}, 1'b1} << st);
  assign tidx  = j << (LOG2N - 1 - st);

  // complex multiply of the b word by the twiddle
  logic signed [TWW-1:0]    w_c, w_s;
  logic signed [DW-1:0]     b_re, b_im;
  logic signed [DW+TWW-1:0] m_rc, m_is, m_ic, m_rs;
  logic signed [PW-1:0]     p_re, p_im, r_re, r_im;
  assign w_c  = tw_cos[tidx];
  assign w_s  = tw_sin[tidx];
  assign b_re = mem_rdata[2*DW-1:DW];
  assign b_im = mem_rdata[DW-1:0];
  assign m_rc = b_re * w_c;
  assign m_is = b_im * w_s;
  assign m_ic = b_im * w_c;
  assign m_rs = b_re * w_s;
  assign p_re = inv ? ({m_rc[DW+TWW-1], m_rc} - {m_is[DW+TWW-1], m_is})
                    : ({m_rc[DW+TWW-1], m_rc} + {m_is[DW+TWW-1], m_is});
  assign p_im = inv ? ({m_ic[DW+TWW-1], m_ic} + {m_rs[DW+TWW-1], m_rs})
                    : ({m_ic[DW+TWW-1], m_ic} - {m_rs[DW+TWW-1], m_rs});
  assign r_re = p_re + RC;
  assign r_im = p_im + RC;

  logic unused_bits;
  assign unused_bits = ^{r_re[PW-1], r_re[TFRAC-1:0], r_im[PW-1], r_im[TFRAC-1:0]};

  // sum/difference with rounded halving and saturation
  function automatic logic signed [DW-1:0] halve_sat(input logic signed [DW+2:0] v);
    logic signed [DW+2:0] h;
    h = (v + $signed({{(DW+2){1'b0}}, 1'b1})) >>> 1;
    if (&h[DW+2:DW-1] || ~|h[DW+2:DW-1]) return h[DW-1:0];
    return h[DW+2] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
  endfunction

  logic signed [DW+2:0] ue_re, ue_im, te_re, te_im;
  assign ue_re = {{3{u_re[DW-1]}}, u_re};
  assign ue_im = {{3{u_im[DW-1]}}, u_im};
  assign te_re = {t_re[DW+1], t_re};
  assign te_im = {t_im[DW+1], t_im};

  logic [2*DW-1:0] sum_w, dif_w;
  assign sum_w = {halve_sat(ue_re + te_re), halve_sat(ue_im + te_im)};
  assign dif_w = {halve_sat(ue_re - te_re), halve_sat(ue_im - te_im)};

  assign mem_addr  = (state == S_RB || state == S_WB) ? b : a;
  assign mem_wr    = (state == S_WA || state == S_WB);
  assign mem_wdata = (state == S_WB) ? dif_w : sum_w;
  assign done      = done_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      st     <= '0;
      bf     <= '0;
      inv    <= 1'b0;
      done_r <= 1'b0;
      u_re   <= '0;
      u_im   <= '0;
      t_re   <= '0;
      t_im   <= '0;
    end else begin
      done_r <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          inv   <= inverse;
          st    <= '0;
          bf    <= '0;
          state <= S_RA;
        end
        S_RA:  state <= S_RB;
        S_RB: begin
          u_re  <= b_re;
          u_im  <= b_im;
          state <= S_MUL;
        end
        S_MUL: begin
          t_re  <= r_re[TFRAC+DW+1:TFRAC];
          t_im  <= r_im[TFRAC+DW+1:TFRAC];
          state <= S_WA;
        end
        S_WA:  state <= S_WB;
        S_WB: begin
          state <= S_RA;
          bf    <= bf + 1'b1;
          if (&bf) begin
            st <= st + 1'b1;
            if (st == SW'(LOG2N - 1)) begin
              state  <= S_IDLE;
              done_r <= 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mem_wr) && !mem_wr));
  a_r3_write_to_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !$past(mem_wr)) |-> (mem_addr == $past(mem_addr, 3)));
  a_r3_reads_before_writes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !$past(mem_wr, 2));
  a_r2_pair_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(mem_wr)) |-> ($countones(mem_addr ^ $past(mem_addr)) == 1));
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && !(state == S_WB && done_r == 1'b0 && &bf && st == SW'(LOG2N-1)))
      |=> (state != S_IDLE));
endmodule

// File: tb/fft_inplace_engine_test.sv
module fft_inplace_engine_test;
  localparam int LOG2N = 4;
  localparam int N     = 1 << LOG2N;
  localparam int HN    = N / 2;
  localparam int TOL   = 6;
  localparam int RUNCY = 5 * HN * LOG2N + 1;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic inverse = 1'b0;
  logic [LOG2N-1:0] mem_addr;
  logic mem_wr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic done;

  fft_inplace_engine #(.LOG2N(LOG2N), .DW(16), .TWW(16)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .inverse(inverse),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done));

  always #4 clk = ~clk;

  logic [31:0] mem [N];
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  int wlog [2*HN*LOG2N];
  int wcnt = 0;
  always @(posedge clk) if (mem_wr && wcnt < 2*HN*LOG2N) begin
    wlog[wcnt] = int'(mem_addr);
    wcnt = wcnt + 1;
  end

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int xr [N];
  int xi [N];

  task automatic check(input string req, input int act, input int exp, input int tol);
    checks++;
    if (act - exp > tol || exp - act > tol) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rev(input int v);
    int r = 0;
    for (int i = 0; i < LOG2N; i++) if (v & (1 << i)) r |= 1 << (LOG2N - 1 - i);
    return r;
  endfunction

  task automatic load();
    for (int n = 0; n < N; n++) mem[rev(n)] = {xr[n][15:0], xi[n][15:0]};
  endtask

  task automatic run(input bit inv, input bit poke, input string req);
    int cnt = 0;
    int dones = 0;
    @(negedge clk);
    start = 1'b1; inverse = inv;
    @(posedge clk); #1;
    start = 1'b0;
    do begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 40) begin start = 1'b1; inverse = ~inv; end
      if (poke && cnt == 41) begin start = 1'b0; inverse = inv; end
    end while (!done && cnt < 4 * RUNCY);
    check({req, " done cycle"}, cnt, RUNCY, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (done) dones++;
    end
    check({req, " done single pulse"}, dones, 0, 0);
  endtask

  task automatic compare(input bit inv, input string req);
    for (int k = 0; k < N; k++) begin
      real sr = 0.0, si = 0.0;
      for (int n = 0; n < N; n++) begin
        real c = $cos(TWO_PI * n * k / N);
        real s = $sin(TWO_PI * n * k / N);
        if (!inv) begin
          sr += xr[n] * c + xi[n] * s;
          si += xi[n] * c - xr[n] * s;
        end else begin
          sr += xr[n] * c - xi[n] * s;
          si += xi[n] * c + xr[n] * s;
        end
      end
      check({req, " re"}, int'($signed(mem[k][31:16])), $rtoi($floor(sr / N + 0.5)), TOL);
      check({req, " im"}, int'($signed(mem[k][15:0])), $rtoi($floor(si / N + 0.5)), TOL);
    end
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lf = 32'h1ACE;
    int idx = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R1 done after reset", int'(done), 0, 0);
      check("R1 no write after reset", int'(mem_wr), 0, 0);
    end

    // R4 pseudo-random complex input, and R2 write order
    for (int n = 0; n < N; n++) begin
      lf = (lf * 1103515245 + 12345) & 32'h7fffffff;
      xr[n] = ((lf >> 8) % 16001) - 8000;
      lf = (lf * 1103515245 + 12345) & 32'h7fffffff;
      xi[n] = ((lf >> 8) % 16001) - 8000;
    end
    load();
    wcnt = 0;
    run(1'b0, 1'b0, "R6 fwd random");
    compare(1'b0, "R4 fwd random");
    check("R2 write count", wcnt, 2 * HN * LOG2N, 0);
    for (int s = 1; s <= LOG2N; s++)
      for (int k = 0; k < N; k += (1 << s))
        for (int j = 0; j < (1 << (s - 1)); j++) begin
          check("R2 write addr a", wlog[idx], k + j, 0);
          check("R2 write addr b", wlog[idx + 1], k + j + (1 << (s - 1)), 0);
          idx += 2;
        end

    // R4 impulse
    for (int n = 0; n < N; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[0] = 16000;
    load(); run(1'b0, 1'b0, "R6 fwd impulse"); compare(1'b0, "R4 fwd impulse");

    // R4 off-grid complex tone
    for (int n = 0; n < N; n++) begin
      xr[n] = $rtoi(12000.0 * $cos(TWO_PI * 3.3 * n / N));
      xi[n] = $rtoi(9000.0 * $sin(TWO_PI * 1.7 * n / N));
    end
    load(); run(1'b0, 1'b0, "R6 fwd tone"); compare(1'b0, "R4 fwd tone");

    // R8 near full-scale DC with modulus below 2^15
    for (int n = 0; n < N; n++) begin xr[n] = 23000; xi[n] = -23000; end
    load(); run(1'b0, 1'b0, "R6 fwd dc");
    compare(1'b0, "R8 full-scale dc");

    // R5 inverse of a single bin and of a random spectrum
    for (int n = 0; n < N; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[5] = 20000; xi[5] = -10000;
    load(); run(1'b1, 1'b0, "R6 inv bin"); compare(1'b1, "R5 inv bin");
    for (int n = 0; n < N; n++) begin
      lf = (lf * 1103515245 + 12345) & 32'h7fffffff;
      xr[n] = ((lf >> 8) % 14001) - 7000;
      xi[n] = 3000 - 400 * n;
    end
    load(); run(1'b1, 1'b0, "R6 inv random"); compare(1'b1, "R5 inv random");

    // R7 start with opposite direction mid-run is ignored
    load(); run(1'b1, 1'b1, "R7 restart ignored"); compare(1'b1, "R7 direction kept");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule